// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block turns one starting word address into the four word addresses of a burst. A start address is captured whenever either of two independent address strobes is high at a rising clock edge. It might come from a processor or from a cache controller. From then on the block produces each following beat address by itself. It moves one step only on edges where the advance input is high.

Only the two low-order bits follow the burst order. The bits above them are passed through from the captured address and never change during the burst. The order is chosen at each load. In linear order the low bits count up modulo four. In interleaved order the low bits are the start bits XORed with the beat number, which is the order processor cache-line fills expect. A registered flag marks the fourth beat of the burst.

Top module: `burst_addr_gen`

## Requirements
- R1: When strobe_cpu or strobe_ctl is 1 at a rising edge, then after that edge addr_out equals the sampled addr_in and last_beat is 0. Either strobe alone is enough.
- R2: When no strobe is active and advance is 0 at an edge, addr_out and last_beat keep their values. When advance is 1, the burst moves exactly one beat.
- R3: A burst loaded with order_ilv = 0 is linear. On beat n (n = 0..3), addr_out[1:0] equals (start[1:0] + n) mod 4.
- R4: A burst loaded with order_ilv = 1 is interleaved. On beat n, addr_out[1:0] equals start[1:0] XOR n.
- R5: order_ilv is sampled only at a load edge. Changing it during a burst has no effect on the sequence.
- R6: When a strobe and advance are both 1 at the same edge, the strobe wins. The block reloads to beat 0 of the new address.
- R7: Advancing from the fourth beat returns to beat 0, which is the first address of the burst. There is no carry into addr_out[ADDR_W-1:2].
- R8: last_beat is 1 exactly while the burst is on its fourth beat (n = 3).
- R9: A synchronous reset (rst = 1 at an edge) sets addr_out to 0, the beat count to 0, last_beat to 0 and the order to linear.
- R10: Between loads, addr_out[ADDR_W-1:2] stays equal to the upper bits of the captured address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_cpu | input | 1 | Processor-side address strobe; loads a new start address |
| strobe_ctl | input | 1 | Controller-side address strobe; loads a new start address |
| advance | input | 1 | Steps the burst by one beat when high and no strobe is active |
| order_ilv | input | 1 | Burst order captured at load: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | Start address sampled on a load |
| addr_out | output | ADDR_W | Current burst word address |
| last_beat | output | 1 | High while the burst is on its fourth beat |

## Verification
On every cycle, the assertions check several properties: the load capture, the priority of a strobe over advance, holding when idle, upper bits that do not move, a one-step change of the low bits in the order that was loaded, the flag rising before the fourth beat and the wrap that follows it, and the reset state. Other behaviour can be shown only by the bench's scenarios. These are: whole sequences compared against independently computed addresses for several start values in both orders, loads through each strobe, a mode change in the middle of a burst, and a reset in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Beat counter width; a burst covers 2**BCNT_W words.
  localparam int BCNT_W = 2;
  localparam int BEATS  = 1 << BCNT_W;

  typedef logic [BCNT_W-1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_ILV    = 1'b1
  } order_e;

  // Linear order: low bits count up from the start and wrap.
  function automatic beat_t lin_low(beat_t start, beat_t beat);
    return beat_t'(start + beat);
  endfunction

  // Interleaved order: low bits are the start flipped by the beat number.
  function automatic beat_t ilv_low(beat_t start, beat_t beat);
    return start ^ beat;
  endfunction

  // True on the final beat of a burst.
  function automatic logic is_final(beat_t beat);
    return beat == beat_t'(BEATS - 1);
  endfunction
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl (
  input  logic strobe_cpu,
  input  logic strobe_ctl,
  input  logic advance,
  output logic load_ev,
  output logic step_ev
);
  // A strobe on either side reloads; advance only counts when no strobe.
  always_comb begin
    load_ev = strobe_cpu | strobe_ctl;
    step_ev = advance & ~load_ev;
  end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load_ev,
  input  logic  step_ev,
  output beat_t beat_q,
  output logic  last_q
);
  beat_t beat_d;

  always_comb begin
    beat_d = beat_q;
    if (load_ev)      beat_d = '0;
    else if (step_ev) beat_d = beat_t'(beat_q + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
      last_q <= 1'b0;
    end else begin
      beat_q <= beat_d;
      last_q <= is_final(beat_d);
    end
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_ev,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] base_q,
  output order_e            order_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      order_q <= ORD_LINEAR;
    end else if (load_ev) begin
      base_q  <= addr_in;
      order_q <= order_ilv ? ORD_ILV : ORD_LINEAR;
    end
  end
endmodule

// File: rtl/burst_lane_map.sv
module burst_lane_map
  import burst_pkg::*;
(
  input  beat_t  start,
  input  beat_t  beat,
  input  order_e order,
  output beat_t  low
);
  beat_t lin_w;
  beat_t ilv_w;

  // Interleaved lanes are independent bit flips; build one per bit.
  for (genvar i = 0; i < BCNT_W; i++) begin : g_ilv_lane
    assign ilv_w[i] = start[i] ^ beat[i];
  end

  always_comb begin
    lin_w = lin_low(start, beat);
    low   = (order == ORD_ILV) ? ilv_w : lin_w;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              advance,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              last_beat
);
  localparam int UP_W = ADDR_W - BCNT_W;

  // Named internal events, visible to the bound checker.
  logic              load_ev;
  logic              step_ev;
  beat_t             beat_q;
  order_e            order_q;
  logic              ilv_q;
  logic [ADDR_W-1:0] base_q;
  beat_t             low_w;

  burst_load_ctrl u_ctrl (
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .advance    (advance),
    .load_ev    (load_ev),
    .step_ev    (step_ev)
  );

  burst_beat_cnt u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load_ev (load_ev),
    .step_ev (step_ev),
    .beat_q  (beat_q),
    .last_q  (last_beat)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk       (clk),
    .rst       (rst),
    .load_ev   (load_ev),
    .addr_in   (addr_in),
    .order_ilv (order_ilv),
    .base_q    (base_q),
    .order_q   (order_q)
  );

  burst_lane_map u_map (
    .start (base_q[BCNT_W-1:0]),
    .beat  (beat_q),
    .order (order_q),
    .low   (low_w)
  );

  assign ilv_q    = (order_q == ORD_ILV);
  assign addr_out = {base_q[ADDR_W-1 -: UP_W], low_w};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe_cpu,
  input logic              strobe_ctl,
  input logic              advance,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              last_beat,
  input logic              load_ev,
  input logic              step_ev,
  input beat_t             beat_q,
  input logic              ilv_q
);
  p_load_capture_r1: assert property (@(posedge clk) disable iff (rst)
    (strobe_cpu || strobe_ctl) |=> (addr_out == $past(addr_in)) && !last_beat);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!load_ev && !advance) |=> $stable(addr_out) && $stable(last_beat));

  p_linear_step_r3: assert property (@(posedge clk) disable iff (rst)
    (step_ev && !ilv_q) |=>
      addr_out[BCNT_W-1:0] == beat_t'($past(addr_out[BCNT_W-1:0]) + 1'b1));

  p_ilv_step_r4: assert property (@(posedge clk) disable iff (rst)
    (step_ev && ilv_q) |=>
      (addr_out[BCNT_W-1:0] ^ $past(addr_out[BCNT_W-1:0])) ==
      ($past(beat_q) ^ beat_t'($past(beat_q) + 1'b1)));

  p_order_held_r5: assert property (@(posedge clk) disable iff (rst)
    !load_ev |=> $stable(ilv_q));

  p_strobe_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (load_ev && advance) |=> beat_q == '0);

  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (step_ev && last_beat) |=> !last_beat && beat_q == '0);

  p_last_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (step_ev && beat_q == beat_t'(BEATS - 2)) |=> last_beat);

  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (addr_out == '0) && !last_beat && beat_q == '0 && !ilv_q);

  p_upper_fixed_r10: assert property (@(posedge clk) disable iff (rst)
    !load_ev |=> $stable(addr_out[ADDR_W-1:BCNT_W]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .strobe_cpu (strobe_cpu),
  .strobe_ctl (strobe_ctl),
  .advance    (advance),
  .addr_in    (addr_in),
  .addr_out   (addr_out),
  .last_beat  (last_beat),
  .load_ev    (load_ev),
  .step_ev    (step_ev),
  .beat_q     (beat_q),
  .ilv_q      (ilv_q)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst, strobe_cpu, strobe_ctl, advance, order_ilv;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic          last_beat;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
    .advance(advance), .order_ilv(order_ilv), .addr_in(addr_in),
    .addr_out(addr_out), .last_beat(last_beat)
  );

  // Expected burst address for beat n, restated from R3, R4, R7 and R10.
  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] s, int n, bit ilv);
    logic [1:0] lo;
    if (ilv) lo = {s[1] ^ n[1], s[0] ^ n[0]};
    else     lo = 2'((int'(s[1:0]) + n) % 4);
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive at the falling edge, then sample 1 ns after the next rising edge.
  task automatic cyc(bit r, bit sc, bit st, bit adv, bit ilv, logic [AW-1:0] a);
    @(negedge clk);
    rst = r; strobe_cpu = sc; strobe_ctl = st; advance = adv; order_ilv = ilv; addr_in = a;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset_state();
    cyc(1, 0, 0, 0, 0, 16'hFFFF);
    check("R9 addr", addr_out, '0);
    check("R9 last", 16'(last_beat), 16'd0);
  endtask

  // One full burst plus the wrap beat.
  task automatic t_burst(logic [AW-1:0] s, bit via_ctl, bit ilv, bit flip_mode);
    string rq;
    rq = ilv ? "R4" : "R3";
    cyc(0, !via_ctl, via_ctl, 0, ilv, s);
    check("R1 load", addr_out, s);
    check("R8 first", 16'(last_beat), 16'd0);
    for (int n = 1; n <= 4; n++) begin
      // R5: the order input toggles during the burst and must be ignored.
      cyc(0, 0, 0, 1, flip_mode ? (n[0] ^ !ilv) : ilv, 16'h0000);
      check(n == 4 ? "R7 wrap" : rq, addr_out, expect_addr(s, n % 4, ilv));
      check("R8 last", 16'(last_beat), 16'(n % 4 == 3));
    end
  endtask

  task automatic t_hold();
    logic [AW-1:0] s;
    s = 16'hA5C1;
    cyc(0, 1, 0, 0, 1, s);
    cyc(0, 0, 0, 1, 1, 16'h0);
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 0, 0, 0, 16'h1234);
      check("R2 hold", addr_out, expect_addr(s, 1, 1));
    end
    cyc(0, 0, 0, 1, 0, 16'h0);
    check("R2 step", addr_out, expect_addr(s, 2, 1));
    check("R10 upper", {addr_out[AW-1:2], 2'b00}, {s[AW-1:2], 2'b00});
  endtask

  task automatic t_strobe_wins();
    cyc(0, 0, 1, 0, 0, 16'h4001);
    cyc(0, 0, 0, 1, 0, 16'h0);
    cyc(0, 0, 0, 1, 0, 16'h0);
    cyc(0, 1, 0, 1, 1, 16'h7FFE);
    check("R6 reload", addr_out, 16'h7FFE);
    check("R6 last", 16'(last_beat), 16'd0);
    cyc(0, 0, 0, 1, 0, 16'h0);
    check("R6 next", addr_out, expect_addr(16'h7FFE, 1, 1));
  endtask

  task automatic t_mid_reset();
    cyc(0, 1, 0, 0, 1, 16'hBEEF);
    cyc(0, 0, 0, 1, 1, 16'h0);
    cyc(0, 0, 0, 1, 1, 16'h0);
    cyc(1, 0, 0, 1, 1, 16'h0);
    check("R9 mid addr", addr_out, '0);
    check("R9 mid last", 16'(last_beat), 16'd0);
    cyc(0, 0, 0, 1, 0, 16'h0);
    check("R9 linear after reset", addr_out, 16'h0001);
  endtask

  initial begin
    rst = 1'b1; strobe_cpu = 0; strobe_ctl = 0; advance = 0; order_ilv = 0; addr_in = '0;
    t_reset_state();
    t_burst(16'h1236, 0, 0, 0);
    t_burst(16'hFFFF, 1, 0, 0);
    t_burst(16'h0C01, 0, 1, 0);
    t_burst(16'h8003, 1, 1, 0);
    t_burst(16'h5552, 0, 1, 1);
    t_burst(16'h2221, 1, 0, 1);
    t_hold();
    t_strobe_wins();
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule